// File: doc/BRIEF.md
# Wide-Access UART FIFO Data Port

This block is the host-facing data window for one UART channel. It sits between a 32-bit memory-mapped host bus and the channel's receive and transmit byte FIFOs. One host read can pop up to four received bytes at once and packs them into byte lanes. One host write can push up to four bytes. A single access therefore moves as many bytes as the host enables, and a burst of dword beats can drain or fill a 64-byte FIFO in 16 accesses.

A second read window pairs each received byte with a status byte that holds its line errors. Software therefore never has to read a separate line-status register. A narrow holding-register location at offset 0x000 keeps the older one-byte-per-access behaviour. The FIFOs expose their oldest four entries and a clipped fill level. The block returns how many entries to pop or push in the same cycle as the bus strobe. Read data comes back registered, one cycle later.

Top module: `uart_wide_port`

## Requirements
- R1: The block acts only on addresses whose bit 9 equals the `CHAN` parameter (0 selects offsets 0x000–0x1FF, 1 selects 0x200–0x3FF). For any other address it pops nothing, pushes nothing and keeps `rd_valid` low.
- R2: A read in the data window (channel offset 0x100–0x13F) takes as many bytes as there are set bits in `be`. The oldest byte goes to the lowest enabled lane, the next oldest to the next enabled lane, and so on. `rx_pop_cnt` carries that count in the same cycle as the strobe.
- R3: `rd_data`, `rd_valid` and `rd_underflow` are registered and appear one cycle after the read strobe. Lanes that are not filled read 0x00. After reset all three are zero.
- R4: When a read asks for more bytes than `rx_avail`, the lanes left unfilled read 0x00. Only the available bytes are popped, and `rd_underflow` is high alongside `rd_valid`.
- R5: A read in the status window (offset 0x180–0x1FF) returns pairs. Lane 0 holds the data byte and lane 1 its status; lane 2 holds the next byte and lane 3 its status. A pair is taken when either of its two byte enables is set, and each pair taken pops one byte.
- R6: The status byte is laid out as follows. Bit 0 is data-ready and is 1 for a byte that is present. Bits 1 to 4 are `rx_peek_err` bits 0 to 3, which are overrun, parity, framing and break. Bits 7 to 5 are zero. An absent pair reads as 0x0000.
- R7: A write in the data window pushes the enabled lanes in ascending lane order. They are packed from lane 0 of `tx_push_data`, and `tx_push_cnt` gives the number pushed.
- R8: Enabled bytes beyond `tx_room` are dropped, and `tx_overflow` pulses high one cycle after the write.
- R9: The holding register (offset 0x000–0x003) uses lane 0 only. A read pops at most one byte into lane 0. A write pushes only lane 0 of `wdata`. All other lanes are ignored.
- R10: A write to the status window pushes nothing. An access to an unmapped offset pops and pushes nothing, and a read there returns 0.
- R11: Every dword address inside a window behaves the same way, so burst beats at incrementing addresses each pop or push their own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Byte address of the access |
| be | input | LANES | Byte-lane enables |
| wdata | input | LANES*BYTE_W | Write data |
| rd_data | output | LANES*BYTE_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_underflow | output | 1 | Read asked for more bytes than were held |
| rx_peek_data | input | LANES*BYTE_W | Oldest RX FIFO bytes, entry 0 in the low byte |
| rx_peek_err | input | LANES*ERR_W | Error bits captured with each RX entry |
| rx_avail | input | LVL_W | RX entries present, clipped to LANES |
| rx_pop_cnt | output | LVL_W | Entries to pop this cycle |
| tx_room | input | LVL_W | TX free slots, clipped to LANES |
| tx_push_data | output | LANES*BYTE_W | Bytes to push, packed from lane 0 |
| tx_push_cnt | output | LVL_W | Entries to push this cycle |
| tx_overflow | output | 1 | Bytes were dropped on the last write |

## Verification
Most internal faults in this block show up at the FIFO side in the same cycle as the strobe. A wrong lane counter or a wrong window decode gives a `rx_pop_cnt` or `tx_push_cnt` that differs from the number of enabled lanes, and this drains or stalls the bench FIFO model at once. Faults in the packing or in the status byte show up one cycle later, when the registered `rd_data` has a byte in the wrong lane or a wrong error bit. Faults in underflow and overflow handling show up on the flags in that same following cycle, and as bytes missing from the bench's FIFO contents.

// File: rtl/uart_win_pkg.sv
package uart_win_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_DATA = 2'd1,
      WIN_STAT = 2'd2,
      WIN_HOLD = 2'd3
   } win_e;
endpackage

// File: rtl/uwin_decode.sv
module uwin_decode
   import uart_win_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int CHAN   = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              chan_hit,
   output win_e              win
);
   localparam int CH_BIT = 9;

   logic [CH_BIT-1:0] off;
   logic              unused_lo;

   assign off       = addr[CH_BIT-1:0];
   assign unused_lo = ^off[1:0];
   assign chan_hit  = (addr[CH_BIT] == CHAN[0]);

   always_comb begin
      if (off[8:6] == 3'b100)      win = WIN_DATA;
      else if (off[8:7] == 2'b11)  win = WIN_STAT;
      else if (off[8:2] == '0)     win = WIN_HOLD;
      else                         win = WIN_NONE;
   end
endmodule

// File: rtl/uwin_rx_pack.sv
module uwin_rx_pack
   import uart_win_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int ERR_W  = 4,
   parameter int LVL_W  = 3
) (
   input  logic                    rd,
   input  win_e                    win,
   input  logic [LANES-1:0]        be,
   input  logic [LANES*BYTE_W-1:0] peek_data,
   input  logic [LANES*ERR_W-1:0]  peek_err,
   input  logic [LVL_W-1:0]        avail,
   output logic [LANES*BYTE_W-1:0] rdata,
   output logic [LVL_W-1:0]        pop_cnt,
   output logic                    underflow
);
   localparam int PAIRS = LANES / 2;
   localparam int IDX_W = $clog2(LANES);
   localparam int PAD   = BYTE_W - ERR_W - 1;

   logic [BYTE_W-1:0] dbyte [LANES];
   logic [BYTE_W-1:0] sbyte [LANES];
   logic              uf;

   for (genvar g = 0; g < LANES; g++) begin : g_ent
      assign dbyte[g] = peek_data[g*BYTE_W +: BYTE_W];
      if (PAD > 0) begin : g_pad
         assign sbyte[g] = {{PAD{1'b0}}, peek_err[g*ERR_W +: ERR_W], 1'b1};
      end else begin : g_nopad
         assign sbyte[g] = {peek_err[g*ERR_W +: ERR_W], 1'b1};
      end
   end

   always_comb begin
      int k;
      k     = 0;
      rdata = '0;
      uf    = 1'b0;
      case (win)
         WIN_DATA: begin
            for (int i = 0; i < LANES; i++) begin
               if (be[i]) begin
                  if (k < int'(avail)) begin
                     rdata[i*BYTE_W +: BYTE_W] = dbyte[k[IDX_W-1:0]];
                     k++;
                  end else begin
                     uf = 1'b1;
                  end
               end
            end
         end
         WIN_STAT: begin
            for (int p = 0; p < PAIRS; p++) begin
               if (|be[2*p +: 2]) begin
                  if (k < int'(avail)) begin
                     rdata[2*p*BYTE_W +: BYTE_W]     = dbyte[k[IDX_W-1:0]];
                     rdata[(2*p+1)*BYTE_W +: BYTE_W] = sbyte[k[IDX_W-1:0]];
                     k++;
                  end else begin
                     uf = 1'b1;
                  end
               end
            end
         end
         WIN_HOLD: begin
            if (be[0]) begin
               if (avail != '0) begin
                  rdata[BYTE_W-1:0] = dbyte[0];
                  k = 1;
               end else begin
                  uf = 1'b1;
               end
            end
         end
         default: ;
      endcase
      pop_cnt   = rd ? LVL_W'(k) : '0;
      underflow = rd & uf;
   end
endmodule

// File: rtl/uwin_tx_pack.sv
module uwin_tx_pack
   import uart_win_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int LVL_W  = 3
) (
   input  logic                    wr,
   input  win_e                    win,
   input  logic [LANES-1:0]        be,
   input  logic [LANES*BYTE_W-1:0] wdata,
   input  logic [LVL_W-1:0]        room,
   output logic [LANES*BYTE_W-1:0] push_data,
   output logic [LVL_W-1:0]        push_cnt,
   output logic                    overflow
);
   logic [LANES-1:0] lane_ok;
   logic             of;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
         assign lane_ok[g] = (win == WIN_DATA) || (win == WIN_HOLD);
      end else begin : g_rest
         assign lane_ok[g] = (win == WIN_DATA);
      end
   end

   always_comb begin
      int k;
      k         = 0;
      push_data = '0;
      of        = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (be[i] && lane_ok[i]) begin
            if (k < int'(room)) begin
               push_data[k*BYTE_W +: BYTE_W] = wdata[i*BYTE_W +: BYTE_W];
               k++;
            end else begin
               of = 1'b1;
            end
         end
      end
      push_cnt = wr ? LVL_W'(k) : '0;
      overflow = wr & of;
   end
endmodule

// File: rtl/uart_wide_port.sv
module uart_wide_port
   import uart_win_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int ERR_W  = 4,
   parameter int CHAN   = 0,
   localparam int LVL_W = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        be,
   input  logic [LANES*BYTE_W-1:0] wdata,
   output logic [LANES*BYTE_W-1:0] rd_data,
   output logic                    rd_valid,
   output logic                    rd_underflow,
   input  logic [LANES*BYTE_W-1:0] rx_peek_data,
   input  logic [LANES*ERR_W-1:0]  rx_peek_err,
   input  logic [LVL_W-1:0]        rx_avail,
   output logic [LVL_W-1:0]        rx_pop_cnt,
   input  logic [LVL_W-1:0]        tx_room,
   output logic [LANES*BYTE_W-1:0] tx_push_data,
   output logic [LVL_W-1:0]        tx_push_cnt,
   output logic                    tx_overflow
);
   if (ADDR_W != 10)                   $error("ADDR_W must be 10");
   if (LANES < 2 || (LANES & (LANES - 1)) != 0)
                                       $error("LANES must be a power of two >= 2");
   if (BYTE_W < ERR_W + 1)             $error("BYTE_W too narrow for status");
   if (CHAN != 0 && CHAN != 1)         $error("CHAN must be 0 or 1");

   logic                    chan_hit;
   win_e                    win;
   logic                    rd_go, wr_go;
   logic [LANES*BYTE_W-1:0] rd_next;
   logic                    uf_now, of_now;

   assign rd_go = rd_en & chan_hit;
   assign wr_go = wr_en & chan_hit;

   uwin_decode #(.ADDR_W(ADDR_W), .CHAN(CHAN)) u_dec (
      .addr     (addr),
      .chan_hit (chan_hit),
      .win      (win)
   );

   uwin_rx_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .ERR_W(ERR_W), .LVL_W(LVL_W)) u_rx (
      .rd        (rd_go),
      .win       (win),
      .be        (be),
      .peek_data (rx_peek_data),
      .peek_err  (rx_peek_err),
      .avail     (rx_avail),
      .rdata     (rd_next),
      .pop_cnt   (rx_pop_cnt),
      .underflow (uf_now)
   );

   uwin_tx_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .LVL_W(LVL_W)) u_tx (
      .wr        (wr_go),
      .win       (win),
      .be        (be),
      .wdata     (wdata),
      .room      (tx_room),
      .push_data (tx_push_data),
      .push_cnt  (tx_push_cnt),
      .overflow  (of_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data      <= '0;
         rd_valid     <= 1'b0;
         rd_underflow <= 1'b0;
         tx_overflow  <= 1'b0;
      end else begin
         rd_data      <= rd_go ? rd_next : '0;
         rd_valid     <= rd_go;
         rd_underflow <= uf_now;
         tx_overflow  <= of_now;
      end
   end
endmodule

// File: rtl/uart_wide_port_chk.sv
module uart_wide_port_chk #(
   parameter int CHAN  = 0,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic             wr_en,
   input logic             addr_ch,
   input logic [LVL_W-1:0] rx_avail,
   input logic [LVL_W-1:0] tx_room,
   input logic [LVL_W-1:0] rx_pop_cnt,
   input logic [LVL_W-1:0] tx_push_cnt,
   input logic             rd_valid,
   input logic             rd_underflow,
   input logic             tx_overflow
);
   // R4
   pop_within_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop_cnt <= rx_avail);
   // R8
   push_within_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push_cnt <= tx_room);
   // R1
   no_pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || addr_ch != CHAN[0]) |-> rx_pop_cnt == '0);
   // R1
   no_push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || addr_ch != CHAN[0]) |-> tx_push_cnt == '0);
   // R3
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr_ch == CHAN[0]) |=> rd_valid);
   // R4
   underflow_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_underflow |-> rd_valid);
   // R8
   overflow_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == 1'b0) |=> !tx_overflow);
endmodule

bind uart_wide_port uart_wide_port_chk #(.CHAN(CHAN), .LVL_W(LVL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_en        (rd_en),
   .wr_en        (wr_en),
   .addr_ch      (addr[9]),
   .rx_avail     (rx_avail),
   .tx_room      (tx_room),
   .rx_pop_cnt   (rx_pop_cnt),
   .tx_push_cnt  (tx_push_cnt),
   .rd_valid     (rd_valid),
   .rd_underflow (rd_underflow),
   .tx_overflow  (tx_overflow)
);

// File: tb/tb_uart_wide_port.sv
`timescale 1ns/1ps
module tb_uart_wide_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic        rd_valid, rd_underflow;
   logic [31:0] rx_peek_data;
   logic [15:0] rx_peek_err;
   logic [2:0]  rx_avail, rx_pop_cnt, tx_room, tx_push_cnt;
   logic [31:0] tx_push_data;
   logic        tx_overflow;

   int total = 0, bad = 0;
   logic [7:0] fq_d [64];
   logic [3:0] fq_e [64];
   int         fcnt = 0;
   logic [7:0] txq [64];
   int         tcnt = 0;
   int         room = 4;

   always #4 clk = ~clk;

   uart_wide_port dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .be(be), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_underflow(rd_underflow), .rx_peek_data(rx_peek_data),
      .rx_peek_err(rx_peek_err), .rx_avail(rx_avail), .rx_pop_cnt(rx_pop_cnt),
      .tx_room(tx_room), .tx_push_data(tx_push_data), .tx_push_cnt(tx_push_cnt),
      .tx_overflow(tx_overflow)
   );

   always_comb begin
      for (int i = 0; i < 4; i++) begin
         rx_peek_data[i*8 +: 8] = (i < fcnt) ? fq_d[i] : 8'hEE;
         rx_peek_err[i*4 +: 4]  = (i < fcnt) ? fq_e[i] : 4'hF;
      end
      rx_avail = (fcnt > 4) ? 3'd4 : 3'(fcnt);
      tx_room  = 3'(room);
   end

   always @(posedge clk) begin
      int n;
      n = int'(rx_pop_cnt);
      if (n > 0) begin
         for (int i = 0; i < 60; i++) begin
            fq_d[i] = fq_d[i+n];
            fq_e[i] = fq_e[i+n];
         end
         fcnt = fcnt - n;
      end
      for (int j = 0; j < int'(tx_push_cnt); j++) txq[tcnt+j] = tx_push_data[j*8 +: 8];
      tcnt = tcnt + int'(tx_push_cnt);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] d, input logic [3:0] e);
      fq_d[fcnt] = d;
      fq_e[fcnt] = e;
      fcnt++;
   endtask

   task automatic rd(input logic [9:0] a, input logic [3:0] b);
      @(negedge clk);
      rd_en = 1'b1; addr = a; be = b;
      @(negedge clk);
      rd_en = 1'b0; be = '0;
   endtask

   task automatic wr(input logic [9:0] a, input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; be = b; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; be = '0;
   endtask

   task automatic t_reset;
      check("R3 reset rd_valid", 32'(rd_valid), 32'd0);
      check("R3 reset rd_data", rd_data, 32'd0);
      check("R8 reset tx_overflow", 32'(tx_overflow), 32'd0);
   endtask

   task automatic t_dword_burst; // R2 R11
      for (int i = 0; i < 8; i++) load(8'h10 + 8'(i), 4'h0);
      rd(10'h100, 4'b1111);
      check("R2 dword lanes", rd_data, 32'h13121110);
      check("R3 valid", 32'(rd_valid), 32'd1);
      rd(10'h104, 4'b1111);
      check("R11 next beat", rd_data, 32'h17161514);
      check("R2 fifo drained", 32'(fcnt), 32'd0);
   endtask

   task automatic t_narrow; // R2
      load(8'hA0, 0); load(8'hA1, 0); load(8'hA2, 0);
      rd(10'h108, 4'b0011);
      check("R2 16-bit", rd_data, 32'h0000A1A0);
      check("R2 pop two", 32'(fcnt), 32'd1);
      rd(10'h13C, 4'b0100);
      check("R2 lane2 byte", rd_data, 32'h00A20000);
      check("R2 no underflow", 32'(rd_underflow), 32'd0);
   endtask

   task automatic t_underflow; // R4
      load(8'h55, 0); load(8'h66, 0);
      rd(10'h100, 4'b1111);
      check("R4 zero fill", rd_data, 32'h00006655);
      check("R4 underflow", 32'(rd_underflow), 32'd1);
      check("R4 popped avail", 32'(fcnt), 32'd0);
   endtask

   task automatic t_status; // R5 R6
      load(8'h41, 4'b0000); load(8'h42, 4'b0101);
      rd(10'h180, 4'b1111);
      check("R5 R6 pairs", rd_data, 32'h0B420141);
      check("R5 two pops", 32'(fcnt), 32'd0);
      load(8'h77, 4'b1000);
      rd(10'h1FC, 4'b0011);
      check("R6 R11 break bit", rd_data, 32'h00001177);
      rd(10'h180, 4'b1111);
      check("R4 status empty", rd_data, 32'h0);
      check("R4 status underflow", 32'(rd_underflow), 32'd1);
   endtask

   task automatic t_write; // R7
      room = 4;
      wr(10'h100, 4'b1111, 32'hDDCCBBAA);
      check("R7 count", 32'(tcnt), 32'd4);
      check("R7 order", {txq[3], txq[2], txq[1], txq[0]}, 32'hDDCCBBAA);
      wr(10'h104, 4'b1010, 32'h44332211);
      check("R7 sparse", {16'h0, txq[5], txq[4]}, 32'h00004422);
      check("R8 no overflow", 32'(tx_overflow), 32'd0);
   endtask

   task automatic t_overflow; // R8
      room = 2;
      wr(10'h13C, 4'b1111, 32'h88776655);
      check("R8 accepted", {16'h0, txq[7], txq[6]}, 32'h00006655);
      check("R8 count", 32'(tcnt), 32'd8);
      check("R8 flag", 32'(tx_overflow), 32'd1);
      room = 4;
   endtask

   task automatic t_hold; // R9
      load(8'h9A, 0); load(8'h9B, 0);
      rd(10'h000, 4'b1111);
      check("R9 one byte", rd_data, 32'h0000009A);
      check("R9 one pop", 32'(fcnt), 32'd1);
      wr(10'h000, 4'b1111, 32'h12345678);
      check("R9 push count", 32'(tcnt), 32'd9);
      check("R9 lane0 only", 32'(txq[8]), 32'h78);
   endtask

   task automatic t_ignored; // R10 R1
      wr(10'h180, 4'b1111, 32'hCAFEF00D);
      check("R10 stat write", 32'(tcnt), 32'd9);
      rd(10'h080, 4'b1111);
      check("R10 unmapped data", rd_data, 32'h0);
      check("R10 unmapped pop", 32'(fcnt), 32'd1);
      rd(10'h300, 4'b1111);
      check("R1 other chan valid", 32'(rd_valid), 32'd0);
      check("R1 other chan pop", 32'(fcnt), 32'd1);
      wr(10'h300, 4'b1111, 32'h01020304);
      check("R1 other chan push", 32'(tcnt), 32'd9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_dword_burst();
      t_narrow();
      t_underflow();
      t_status();
      t_write();
      t_overflow();
      t_hold();
      t_ignored();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule